// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers up to eight level-sensitive interrupt request lines from peripheral modules and presents a single interrupt request to a processor that has one request input and one acknowledge output. It decides which pending source should be serviced, based on a per-source mask, the set of sources already in service and the selected priority scheme. When the processor acknowledges, the controller returns an 8-bit vector for the winning source and records that source as in service until software sends an end-of-interrupt command.

Two priority schemes are available. In fixed nested order, source 0 always outranks source 1, which outranks source 2, and so on down to source 7. In rotating order, the source named by an end-of-interrupt command drops to the bottom of the order, so that sources which request often cannot starve the others. In both schemes a newly pending source can preempt a running handler only if it outranks every source in service.

The processor configures the block through four write-only registers selected by a 2-bit address. The returned vector combines a software-chosen 5-bit base in its upper bits with the 3-bit source number in its lower bits.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, intReq and vecValid are 0, no source is masked, fixed order is selected, the vector base is 0, no source is in service and the bottom of the rotating order is source 7.
- R2: In fixed order, the pending unmasked source with the smallest number wins, and the returned vector is {base[4:0], source[2:0]}.
- R3: A source whose mask bit is 1 neither drives intReq nor wins an acknowledge.
- R4: A rising edge of intAck while intReq is 1 produces vecValid for exactly one cycle, in the cycle after that edge, with the vector of the winner, and sets that source's in-service bit. Holding intAck high gives no second vector.
- R5: intReq is 1 exactly when some unmasked pending source outranks every in-service source. A source of equal or lower rank than an in-service source does not raise intReq.
- R6: An end-of-interrupt command clears the in-service bit of the highest-ranked source in service. If no source is in service it has no effect.
- R7: In rotating order, the source cleared by an end-of-interrupt command becomes the lowest-ranked source, and the source numbered one above it (modulo 8) becomes the highest.
- R8: A rising edge of intAck while intReq is 0 produces no vector and leaves the in-service bits unchanged.
- R9: Writes with regWrEn=1 decode regAddr as follows: 0 sets the mode from data bit 0 (1 = rotating, 0 = fixed), 1 loads the mask (bit n masks source n), 2 loads the vector base from data bits 4:0, 3 issues an end-of-interrupt command. Data is ignored for address 3. Register changes take effect in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqReq | input | 8 | Level-sensitive request lines, bit n is source n |
| intAck | input | 1 | Acknowledge from the processor, rising edge counts |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 8 | Register write data |
| intReq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector of the acknowledged source |
| vecValid | output | 1 | One-cycle marker that vecOut is new |

## Verification
The bench targets a request that ties with an in-service source: a design that compared ranks with less-or-equal would re-interrupt its own handler. It holds intAck high across several cycles, which catches a level-triggered acknowledge handing out repeated vectors and filling the in-service set. It also acknowledges with nothing eligible, which a careless design answers with a stale vector or a stray in-service bit. After end-of-interrupt in rotating mode it checks that the winner follows the new order, which catches a rotation pointer set to the wrong source or left unchanged.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_BASE = 2'd2;
  localparam logic [1:0] ADDR_EOI  = 2'd3;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic wrMode;
    logic wrMask;
    logic wrBase;
    logic eoi;
    logic ack;
  } ctrlStrobe_t;

endpackage

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
  import prio_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic        intAck,
  output ctrlStrobe_t strobe
);

  logic ackPrev;

  always_ff @(posedge clk) begin
    if (!rst_n) ackPrev <= 1'b0;
    else        ackPrev <= intAck;
  end

  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      case (regAddr)
        ADDR_MODE: strobe.wrMode = 1'b1;
        ADDR_MASK: strobe.wrMask = 1'b1;
        ADDR_BASE: strobe.wrBase = 1'b1;
        default:   strobe.eoi    = 1'b1;
      endcase
    end
    strobe.ack = intAck & ~ackPrev;
  end

endmodule

// File: rtl/prio_irq_dp.sv
module prio_irq_dp
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobe_t        strobe,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic [VEC_W-1:0]   wrData,
  output logic               intReq,
  output logic [VEC_W-1:0]   vecOut,
  output logic               vecValid,
  output logic [NUM_SRC-1:0] isrVec,
  output logic [NUM_SRC-1:0] maskVec,
  output logic               modeRot
);

  localparam int IDX_W  = $clog2(NUM_SRC);
  localparam int BASE_W = VEC_W - IDX_W;

  logic               modeRotQ;
  logic [NUM_SRC-1:0] maskQ, isrQ, isrNext;
  logic [BASE_W-1:0]  baseQ;
  logic [IDX_W-1:0]   lowQ, effLow;
  logic [VEC_W-1:0]   vecQ;
  logic               vecValidQ;

  logic [NUM_SRC-1:0] pend, pendRot, isrRot;
  logic [IDX_W-1:0]   srcAt [NUM_SRC];
  logic               pendHit, isHit, eligible;
  logic [IDX_W-1:0]   pendRank, isRank, pendSrc, isSrc;

  assign effLow = modeRotQ ? lowQ : IDX_W'(NUM_SRC - 1);
  assign pend   = irqReq & ~maskQ;

  // Rank g maps to source (g + low + 1) mod NUM_SRC
  for (genvar g = 0; g < NUM_SRC; g++) begin : gRank
    assign srcAt[g]   = IDX_W'(g) + effLow + IDX_W'(1);
    assign pendRot[g] = pend[srcAt[g]];
    assign isrRot[g]  = isrQ[srcAt[g]];
  end

  always_comb begin
    pendHit  = 1'b0;
    pendRank = '0;
    isHit    = 1'b0;
    isRank   = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (pendRot[k]) begin
        pendHit  = 1'b1;
        pendRank = IDX_W'(k);
      end
      if (isrRot[k]) begin
        isHit  = 1'b1;
        isRank = IDX_W'(k);
      end
    end
  end

  assign pendSrc  = srcAt[pendRank];
  assign isSrc    = srcAt[isRank];
  assign eligible = pendHit && (!isHit || (pendRank < isRank));

  always_comb begin
    isrNext = isrQ;
    if (strobe.eoi && isHit)      isrNext[isSrc]   = 1'b0;
    if (strobe.ack && eligible)   isrNext[pendSrc] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeRotQ  <= 1'b0;
      maskQ     <= '0;
      baseQ     <= '0;
      isrQ      <= '0;
      lowQ      <= IDX_W'(NUM_SRC - 1);
      vecQ      <= '0;
      vecValidQ <= 1'b0;
    end else begin
      vecValidQ <= 1'b0;
      if (strobe.wrMode) modeRotQ <= wrData[0];
      if (strobe.wrMask) maskQ    <= wrData[NUM_SRC-1:0];
      if (strobe.wrBase) baseQ    <= wrData[BASE_W-1:0];
      if (strobe.ack && eligible) begin
        vecQ      <= {baseQ, pendSrc};
        vecValidQ <= 1'b1;
      end
      if (strobe.eoi && isHit && modeRotQ) lowQ <= isSrc;
      isrQ <= isrNext;
    end
  end

  assign intReq   = eligible;
  assign vecOut   = vecQ;
  assign vecValid = vecValidQ;
  assign isrVec   = isrQ;
  assign maskVec  = maskQ;
  assign modeRot  = modeRotQ;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               intAck,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [VEC_W-1:0]   regWrData,
  output logic               intReq,
  output logic [VEC_W-1:0]   vecOut,
  output logic               vecValid
);

  ctrlStrobe_t        strobe;
  logic [NUM_SRC-1:0] isrVec;
  logic [NUM_SRC-1:0] maskVec;
  logic               modeRot;

  prio_irq_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .intAck  (intAck),
    .strobe  (strobe)
  );

  prio_irq_dp #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .irqReq   (irqReq),
    .wrData   (regWrData),
    .intReq   (intReq),
    .vecOut   (vecOut),
    .vecValid (vecValid),
    .isrVec   (isrVec),
    .maskVec  (maskVec),
    .modeRot  (modeRot)
  );

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irqReq,
  input logic               intReq,
  input logic [VEC_W-1:0]   vecOut,
  input logic               vecValid,
  input logic [NUM_SRC-1:0] isrVec,
  input logic [NUM_SRC-1:0] maskVec,
  input logic               modeRot
);

  localparam int IDX_W = $clog2(NUM_SRC);

  AST_VEC_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |=> !vecValid); // R4

  AST_VEC_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |-> $past(intReq)); // R8

  AST_VEC_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |-> isrVec[vecOut[IDX_W-1:0]]); // R4

  AST_REQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    intReq |-> (|(irqReq & ~maskVec))); // R3

  AST_TOP_IN_SERVICE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!modeRot && isrVec[0]) |-> !intReq); // R5

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irqReq   (irqReq),
  .intReq   (intReq),
  .vecOut   (vecOut),
  .vecValid (vecValid),
  .isrVec   (isrVec),
  .maskVec  (maskVec),
  .modeRot  (modeRot)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irqReq;
  logic       intAck;
  logic       regWrEn;
  logic [1:0] regAddr;
  logic [7:0] regWrData;
  logic       intReq;
  logic [7:0] vecOut;
  logic       vecValid;

  always #2 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irqReq(irqReq), .intAck(intAck),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .intReq(intReq), .vecOut(vecOut), .vecValid(vecValid)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state built from the requirements
  logic       mRot;
  logic [7:0] mMask, mIsr;
  logic [4:0] mBase;
  logic [2:0] mLow;
  logic       mAckPrev;
  logic       lastValid;
  logic [7:0] lastVec;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Highest-ranked set bit; rank 0 is the source just above the bottom
  function automatic void best(input logic [7:0] v, input logic [2:0] low,
                               output logic hit, output logic [2:0] src, output logic [2:0] rank);
    hit = 0; src = 0; rank = 0;
    for (int r = 0; r < 8; r++) begin
      logic [2:0] s;
      s = 3'(r) + low + 3'd1;
      if (!hit && v[s]) begin
        hit = 1; src = s; rank = 3'(r);
      end
    end
  endfunction

  function automatic logic expectReq(input logic [7:0] req, output logic [2:0] win);
    logic ph, ih; logic [2:0] ps, pr, is_, ir, low;
    low = mRot ? mLow : 3'd7;
    best(req & ~mMask, low, ph, ps, pr);
    best(mIsr, low, ih, is_, ir);
    win = ps;
    return ph && (!ih || pr < ir);
  endfunction

  task automatic cycle(input logic [7:0] req, input logic we, input logic [1:0] addr,
                       input logic [7:0] data, input logic ack);
    logic elig, rise, ih; logic [2:0] win, is_, ir, low; logic [7:0] newIsr;
    @(negedge clk);
    irqReq = req; regWrEn = we; regAddr = addr; regWrData = data; intAck = ack;
    #0.5;
    elig = expectReq(req, win);
    check("R5 intReq", intReq, elig);
    rise = ack && !mAckPrev;
    low  = mRot ? mLow : 3'd7;
    best(mIsr, low, ih, is_, ir);
    newIsr = mIsr;
    if (we && addr == 2'd3 && ih) begin
      newIsr[is_] = 1'b0;
      if (mRot) mLow = is_;
    end
    if (rise && elig) newIsr[win] = 1'b1;
    @(posedge clk);
    #1;
    check("R4 vecValid", vecValid, rise && elig);
    if (rise && elig) check("R2 vecOut", vecOut, {mBase, win});
    lastValid = vecValid;
    lastVec   = vecOut;
    mIsr = newIsr;
    if (we && addr == 2'd0) mRot  = data[0];
    if (we && addr == 2'd1) mMask = data;
    if (we && addr == 2'd2) mBase = data[4:0];
    mAckPrev = ack;
  endtask

  task automatic wr(input logic [7:0] req, input logic [1:0] addr, input logic [7:0] data);
    cycle(req, 1'b1, addr, data, 1'b0);
  endtask

  initial begin
    #(4 * 60000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 0; irqReq = 0; intAck = 0; regWrEn = 0; regAddr = 0; regWrData = 0;
    mRot = 0; mMask = 0; mIsr = 0; mBase = 0; mLow = 3'd7; mAckPrev = 0;
    repeat (4) @(posedge clk);
    #1;
    check("R1 intReq after reset", intReq, 0);
    check("R1 vecValid after reset", vecValid, 0);
    rst_n = 1;

    // R1: every source unmasked, fixed order, base 0 -> source 0 wins with vector 0
    cycle(8'hFF, 0, 0, 0, 1);
    check("R1 reset vector", {lastValid, lastVec}, {1'b1, 8'h00});
    cycle(8'h00, 0, 0, 0, 0);
    wr(8'h00, 2'd3, 8'h00);

    // R9 base write, R2 lowest number wins
    wr(8'h00, 2'd2, 8'hEA);                 // base takes bits 4:0 = 0x0A
    cycle(8'h28, 0, 0, 0, 1);
    check("R2 R9 vector of source 3", lastVec, 8'h53);
    cycle(8'h28, 0, 0, 0, 1);               // R4: held acknowledge
    check("R4 held ack no vector", lastValid, 0);
    check("R5 equal rank blocked", intReq, 0);
    cycle(8'h2A, 0, 0, 0, 0);
    check("R5 higher rank raises", intReq, 1);
    cycle(8'h2A, 0, 0, 0, 1);
    check("R5 nested vector", lastVec, 8'h51);
    cycle(8'h2A, 0, 0, 0, 0);
    wr(8'h2A, 2'd3, 8'h00);                 // R6: clears source 1, not 3
    cycle(8'h2A, 0, 0, 0, 0);
    check("R6 eoi clears top only", intReq, 1);
    wr(8'h2A, 2'd1, 8'h02);                 // R3: mask source 1
    cycle(8'h2A, 0, 0, 0, 0);
    check("R3 masked source silent", intReq, 0);
    wr(8'h2A, 2'd3, 8'h00);
    cycle(8'h00, 0, 0, 0, 1);               // R8: nothing eligible
    check("R8 spurious ack", lastValid, 0);
    cycle(8'h20, 0, 0, 0, 0);
    check("R8 in-service untouched", intReq, 1);

    // R7 rotating order
    wr(8'h00, 2'd1, 8'h00);
    wr(8'h00, 2'd0, 8'h01);
    cycle(8'h09, 0, 0, 0, 1);
    check("R7 first winner", lastVec, 8'h50);
    cycle(8'h09, 0, 0, 0, 0);
    wr(8'h09, 2'd3, 8'h00);
    cycle(8'h09, 0, 0, 0, 1);
    check("R7 serviced source drops", lastVec, 8'h53);
    cycle(8'h21, 0, 0, 0, 0);
    wr(8'h21, 2'd3, 8'h00);
    cycle(8'h21, 0, 0, 0, 1);
    check("R7 order after second rotate", lastVec, 8'h55);
    cycle(8'h00, 0, 0, 0, 0);
    wr(8'h00, 2'd3, 8'h00);

    // Constrained random traffic checked each cycle against the model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] req, data;
      logic we, ack;
      logic [1:0] addr;
      req  = 8'($urandom) & 8'($urandom);
      we   = ($urandom % 6) == 0;
      addr = 2'($urandom);
      data = (addr == 2'd1) ? (8'($urandom) & 8'($urandom)) : 8'($urandom);
      ack  = ($urandom % 3) == 0;
      cycle(req, we, addr, data, ack);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule